// File: doc/BRIEF.md
# Multi-Mode Reloadable Event Timer

This block is a 24-bit event counter with four operating families chosen by a mode field: plain timer, input measurement, PWM and watchdog. It counts events. An event is either a cycle of the timer clock or a qualifying edge on an external pin. The counter is primed from a load register on the first event after the block is enabled. After that it either runs freely or reloads by a rule that depends on the mode. The reload points are:

- a compare match in timer and watchdog modes,
- an overflow in PWM mode,
- each qualifying pin edge in measurement mode.

A compare match sets a sticky flag. That flag drives an interrupt request when the interrupt enable is set. In watchdog mode a match also raises a one-clock timeout strobe, and a write to the load register while enabled restarts the count at once. The pin works as an input in measurement mode and in timer mode with the external clock selected. In every other configuration it is an output carrying a match pulse or a PWM level. An inverter bit chooses the input edge and the output polarity.

Software reaches the block through a two-bit register bus with single-cycle writes and a combinational read port. The four addresses hold the load value, the compare value, the control and status word, and the live count.

Top module: `evt_timer`

## Requirements
- R1: After reset every register and the counter read zero, and `irq`, `wdTimeout` and `pinOut` are low with `pinOutEn` high.
- R2: Address 0 is the write-only load register and always reads zero. Address 3 reads the count. After the enable bit (control bit 0) goes from 0 to 1, the count becomes the load value on the first event. While disabled the count holds.
- R3: Address 1 holds the compare value. While enabled, outside measurement mode and once primed, a count equal to the compare value sets the flag (status bit 8) at the next edge. `irq` is flag AND irq-enable (control bit 3). Writing 1 to bit 8 clears the flag, and a match in the same cycle wins.
- R4: In timer mode (mode field bits 5:4 = 0) and watchdog mode (3) with reload (control bit 1) set, an event that occurs while the count equals the compare value loads the load value instead of incrementing.
- R5: In PWM mode (2) with reload set, an event at count all-ones loads the load value. The PWM level goes to 1 on that event and to 0 one edge after the first cycle of a match.
- R6: In measurement mode (1) the count advances every clock, the compare value never sets the flag, and with reload set each qualifying pin edge loads the load value.
- R7: In watchdog mode, a load-register write while enabled puts the written value into the count at the next edge. The first cycle of a match produces a one-clock `wdTimeout` pulse one edge later.
- R8: With reload clear the counter runs freely in every mode and wraps from 0xFFFFFF to 0.
- R9: The inverter (control bit 2) picks the rising edge (0) or falling edge (1) of the pin after a two-flop synchroniser, so an edge acts three clock edges after the pin changes. On an output it inverts the driven level.
- R10: In timer mode with external clock (control bit 6) set, only qualifying pin edges are events and `pinOutEn` is low. `pinOutEn` is also low in measurement mode. Otherwise the pin outputs the match pulse (timer, watchdog) or the PWM level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 2 | Register address for read and write |
| busWrData | input | 24 | Write data |
| busRdData | output | 24 | Read data for `busAddr` |
| pinIn | input | 1 | External pin, asynchronous |
| pinOut | output | 1 | Pin output level |
| pinOutEn | output | 1 | High when the pin is an output |
| irq | output | 1 | Compare interrupt request |
| wdTimeout | output | 1 | One-clock watchdog timeout strobe |

## Verification
The checker properties assume that no bus write lands in the cycle they observe. For example, the free-run wrap and measurement no-flag properties exclude `busWrEn` cycles, because such a write may legally change the mode or the count. The pin is taken to be slow compared with the clock. The stimulus keeps every pin level for at least three clocks, so the synchroniser sees each edge once. Writes are single-cycle and separated by idle cycles. The reference model replays the same bus and pin activity cycle by cycle and checks every output and the read port on every clock.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_MEASURE = 2'd1,
    MODE_PWM     = 2'd2,
    MODE_WDOG    = 2'd3
  } modeT;

  // packed MSB first: extClk is bit 6, enable is bit 0
  typedef struct packed {
    logic extClk;
    modeT mode;
    logic irqEn;
    logic invert;
    logic reload;
    logic en;
  } cfgT;

  localparam int CFG_W = $bits(cfgT);

  typedef struct packed {
    logic loadNow;
    logic loadFromBus;
    logic incNow;
  } cntStrobeT;

  localparam logic [1:0] ADDR_LOAD = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;
  localparam int         FLAG_BIT  = 8;

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  input  logic             pinIn,
  input  logic             eqCmp,
  input  logic             atMax,
  output cfgT              cfg,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cmpVal,
  output cntStrobeT        strobe,
  output logic             flag,
  output logic             matchNow,
  output logic             firstPend,
  output logic             irq,
  output logic             wdTimeout,
  output logic             pinOut,
  output logic             pinOutEn
);
  logic [CNT_W-1:0] loadQ, cmpQ;
  cfgT  cfgQ;
  logic firstQ, flagQ, prevMatchQ, wdToQ, pulseQ, pwmQ, pinDlyQ;
  logic pinSync;

  evt_timer_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(pinSync)
  );

  logic wrLoad, wrCmp, wrCtl, clrFlag;
  logic extMode, riseEdge, fallEdge, pinEdge, tick;
  logic wdForce, measReload, cycleReload, matchRise, rawOut;

  assign wrLoad  = busWrEn && (busAddr == ADDR_LOAD);
  assign wrCmp   = busWrEn && (busAddr == ADDR_CMP);
  assign wrCtl   = busWrEn && (busAddr == ADDR_CTL);
  assign clrFlag = wrCtl && busWrData[FLAG_BIT];

  assign extMode  = (cfgQ.mode == MODE_TIMER) && cfgQ.extClk;
  assign riseEdge = pinSync && !pinDlyQ;
  assign fallEdge = !pinSync && pinDlyQ;
  assign pinEdge  = cfgQ.invert ? fallEdge : riseEdge;
  assign tick     = cfgQ.en && (extMode ? pinEdge : 1'b1);

  assign wdForce    = cfgQ.en && (cfgQ.mode == MODE_WDOG) && wrLoad;
  assign measReload = cfgQ.en && cfgQ.reload && (cfgQ.mode == MODE_MEASURE) && pinEdge;
  assign cycleReload = cfgQ.reload &&
      ((((cfgQ.mode == MODE_TIMER) || (cfgQ.mode == MODE_WDOG)) && eqCmp) ||
       ((cfgQ.mode == MODE_PWM) && atMax));

  always_comb begin
    strobe = '0;
    if (wdForce) begin
      strobe.loadNow     = 1'b1;
      strobe.loadFromBus = 1'b1;
    end else if (tick && firstQ) begin
      strobe.loadNow = 1'b1;
    end else if (measReload) begin
      strobe.loadNow = 1'b1;
    end else if (tick) begin
      if (cycleReload) strobe.loadNow = 1'b1;
      else             strobe.incNow  = 1'b1;
    end
  end

  assign matchNow  = cfgQ.en && (cfgQ.mode != MODE_MEASURE) && !firstQ && eqCmp;
  assign matchRise = matchNow && !prevMatchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ      <= '0;
      cmpQ       <= '0;
      cfgQ       <= '0;
      firstQ     <= 1'b0;
      flagQ      <= 1'b0;
      prevMatchQ <= 1'b0;
      wdToQ      <= 1'b0;
      pulseQ     <= 1'b0;
      pwmQ       <= 1'b0;
      pinDlyQ    <= 1'b0;
    end else begin
      if (wrLoad) loadQ <= busWrData;
      if (wrCmp)  cmpQ  <= busWrData;
      if (wrCtl)  cfgQ  <= cfgT'(busWrData[CFG_W-1:0]);

      if (wrCtl && busWrData[0] && !cfgQ.en) firstQ <= 1'b1;
      else if (firstQ && (wdForce || tick))  firstQ <= 1'b0;

      flagQ      <= matchNow || (flagQ && !clrFlag);
      prevMatchQ <= matchNow;
      wdToQ      <= matchRise && (cfgQ.mode == MODE_WDOG);
      pulseQ     <= matchRise;
      pinDlyQ    <= pinSync;

      if (!cfgQ.en)                                        pwmQ <= 1'b0;
      else if ((cfgQ.mode == MODE_PWM) && tick && atMax)   pwmQ <= 1'b1;
      else if (matchRise)                                  pwmQ <= 1'b0;
    end
  end

  assign rawOut    = (cfgQ.mode == MODE_PWM) ? pwmQ : pulseQ;
  assign pinOutEn  = (cfgQ.mode != MODE_MEASURE) && !extMode;
  assign pinOut    = pinOutEn && (rawOut ^ cfgQ.invert);
  assign irq       = flagQ && cfgQ.irqEn;
  assign wdTimeout = wdToQ;
  assign cfg       = cfgQ;
  assign loadVal   = loadQ;
  assign cmpVal    = cmpQ;
  assign flag      = flagQ;
  assign firstPend = firstQ;
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobeT        strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] busWrData,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cnt,
  output logic             eqCmp,
  output logic             atMax
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.loadNow) cntQ <= strobe.loadFromBus ? busWrData : loadVal;
    else if (strobe.incNow)  cntQ <= cntQ + 1'b1;
  end

  assign cnt   = cntQ;
  assign eqCmp = (cntQ == cmpVal);
  assign atMax = &cntQ;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOutEn,
  output logic             irq,
  output logic             wdTimeout
);
  cfgT              cfgW;
  cntStrobeT        strobeW;
  logic [CNT_W-1:0] loadW, cmpW, cntW;
  logic             eqW, maxW, flagW, matchW, firstW;

  evt_timer_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .pinIn(pinIn), .eqCmp(eqW), .atMax(maxW),
    .cfg(cfgW), .loadVal(loadW), .cmpVal(cmpW), .strobe(strobeW),
    .flag(flagW), .matchNow(matchW), .firstPend(firstW), .irq(irq),
    .wdTimeout(wdTimeout), .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

  evt_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobeW), .loadVal(loadW),
    .busWrData(busWrData), .cmpVal(cmpW), .cnt(cntW), .eqCmp(eqW), .atMax(maxW)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CMP: busRdData = cmpW;
      ADDR_CTL: begin
        busRdData[CFG_W-1:0] = cfgW;
        busRdData[FLAG_BIT]  = flagW;
      end
      ADDR_CNT: busRdData = cntW;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [1:0]       busAddr,
  input logic [CNT_W-1:0] busWrData,
  input logic             wdTimeout,
  input cfgT              cfg,
  input logic             flag,
  input logic             matchNow,
  input logic             firstPend,
  input logic [CNT_W-1:0] cnt
);
  // R2: a disabled counter with no bus activity keeps its value
  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.en && !busWrEn) |=> $stable(cnt));

  // R3: a write-one clear without a concurrent match leaves the flag low
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTL && busWrData[FLAG_BIT] && !matchNow) |=> !flag);

  // R6: measurement mode never raises the flag
  assert_meas_noflag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_MEASURE && !flag && !busWrEn) |=> !flag);

  // R7: watchdog load write restarts the count from the written value
  assert_wd_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.mode == MODE_WDOG && busWrEn && busAddr == ADDR_LOAD)
      |=> (cnt == $past(busWrData)));

  // R7: timeout strobe lasts exactly one clock
  assert_timeout_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |=> !wdTimeout);

  // R8: free-running count leaves all-ones only towards zero
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && !cfg.reload && !firstPend && !busWrEn && (&cnt))
      |=> ((cnt == '0) || (&cnt)));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .wdTimeout(wdTimeout), .cfg(cfgW), .flag(flagW),
  .matchNow(matchW), .firstPend(firstW), .cnt(cntW)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd3;
  logic [23:0] busWrData = '0;
  logic        pinIn = 1'b0;
  logic [23:0] busRdData;
  logic        pinOut, pinOutEn, irq, wdTimeout;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;  // 125 MHz

  evt_timer dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irq(irq), .wdTimeout(wdTimeout)
  );

  // behavioural reference state
  logic [23:0] mLoad, mCmp, mCnt, nCnt;
  logic [1:0]  mMode;
  logic mEn, mRel, mInv, mIe, mExt;
  logic mFlag, mFirst, mPrev, mWd, mPulse, mPwm, s1, s2, s3;
  logic eg, tk, mt, wrL, wrC, wrK, isTimerLike;

  always @(posedge clk) begin
    if (!rstN) begin
      mLoad = 0; mCmp = 0; mCnt = 0; mMode = 0;
      {mEn, mRel, mInv, mIe, mExt} = '0;
      {mFlag, mFirst, mPrev, mWd, mPulse, mPwm, s1, s2, s3} = '0;
    end else begin
      eg  = mInv ? (!s2 && s3) : (s2 && !s3);
      tk  = mEn && ((mMode == 2'd0 && mExt) ? eg : 1'b1);
      wrL = busWrEn && busAddr == 2'd0;
      wrC = busWrEn && busAddr == 2'd1;
      wrK = busWrEn && busAddr == 2'd2;
      mt  = mEn && mMode != 2'd1 && !mFirst && (mCnt == mCmp);
      isTimerLike = (mMode == 2'd0) || (mMode == 2'd3);
      nCnt = mCnt;
      if (mEn && mMode == 2'd3 && wrL)           nCnt = busWrData;
      else if (tk && mFirst)                     nCnt = mLoad;
      else if (mEn && mRel && mMode == 2'd1 && eg) nCnt = mLoad;
      else if (tk) begin
        if (mRel && ((isTimerLike && mCnt == mCmp) || (mMode == 2'd2 && mCnt == 24'hFFFFFF)))
          nCnt = mLoad;
        else
          nCnt = mCnt + 24'd1;
      end
      if (!mEn) mPwm = 1'b0;
      else if (mMode == 2'd2 && tk && mCnt == 24'hFFFFFF) mPwm = 1'b1;
      else if (mt && !mPrev) mPwm = 1'b0;
      mWd    = mt && !mPrev && mMode == 2'd3;
      mPulse = mt && !mPrev;
      mPrev  = mt;
      mFlag  = mt || (mFlag && !(wrK && busWrData[8]));
      if (wrK && busWrData[0] && !mEn) mFirst = 1'b1;
      else if (mFirst && (tk || (mEn && mMode == 2'd3 && wrL))) mFirst = 1'b0;
      mCnt = nCnt;
      if (wrL) mLoad = busWrData;
      if (wrC) mCmp = busWrData;
      if (wrK) begin
        mEn = busWrData[0]; mRel = busWrData[1]; mInv = busWrData[2];
        mIe = busWrData[3]; mMode = busWrData[5:4]; mExt = busWrData[6];
      end
      s3 = s2; s2 = s1; s1 = pinIn;
    end
  end

  task automatic check(input string name, input logic [23:0] got, input logic [23:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s got %h expected %h", tag, name, got, exp);
    end
  endtask

  logic [23:0] eRd;
  logic ePinEn;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      case (busAddr)
        2'd0: eRd = 24'd0;   // R2: load register reads zero
        2'd1: eRd = mCmp;
        2'd2: eRd = {15'd0, mFlag, 1'b0, mExt, mMode, mIe, mInv, mRel, mEn};
        default: eRd = mCnt;
      endcase
      ePinEn = (mMode != 2'd1) && !(mMode == 2'd0 && mExt);
      check("busRdData", busRdData, eRd);
      check("irq", {23'd0, irq}, {23'd0, mFlag && mIe});
      check("wdTimeout", {23'd0, wdTimeout}, {23'd0, mWd});
      check("pinOutEn", {23'd0, pinOutEn}, {23'd0, ePinEn});
      check("pinOut", {23'd0, pinOut},
            {23'd0, ePinEn && (((mMode == 2'd2) ? mPwm : mPulse) ^ mInv)});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0; busAddr = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setup(input logic [23:0] ld, input logic [23:0] cp, input logic [23:0] ctl);
    wr(2'd2, 24'h000100);  // disable, clear flag
    wr(2'd0, ld);
    wr(2'd1, cp);
    wr(2'd2, ctl);
  endtask

  task automatic pinToggles(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      pinIn = ~pinIn;
      idle(gap);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tag = "R1"; idle(3);
    busAddr = 2'd2; idle(2); busAddr = 2'd3;

    // R2 R3 R4: timer with reload and interrupt
    tag = "R4"; setup(24'd10, 24'd15, 24'h00000B);
    busAddr = 2'd0; idle(2); busAddr = 2'd3;   // R2 readback of load
    idle(20);
    tag = "R3"; wr(2'd2, 24'h000103); idle(3);   // irq disabled, flag clear
    busAddr = 2'd2; idle(8); busAddr = 2'd3;
    wr(2'd2, 24'h00010B); idle(10);

    // R8: free run wrap
    tag = "R8"; setup(24'hFFFFF0, 24'd5, 24'h000009); idle(30);
    busAddr = 2'd2; idle(2); busAddr = 2'd3;

    // R5 R9: PWM both polarities
    tag = "R5"; setup(24'hFFFFF8, 24'hFFFFFC, 24'h000023); idle(30);
    tag = "R9"; setup(24'hFFFFF8, 24'hFFFFFC, 24'h000027); idle(30);

    // R6 R9: measurement, rising then falling edge
    tag = "R6"; setup(24'h000100, 24'h000105, 24'h00001B);
    pinToggles(6, 5);
    busAddr = 2'd2; idle(2); busAddr = 2'd3;
    tag = "R9"; setup(24'h000200, 24'h000203, 24'h00001F);
    pinToggles(6, 4);

    // R7: watchdog timeout and kick
    tag = "R7"; setup(24'd0, 24'd20, 24'h00003B); idle(30);
    wr(2'd0, 24'd5); idle(6); wr(2'd0, 24'd12); idle(12);

    // R10 R9: external clock, both edges
    tag = "R10"; setup(24'd3, 24'd6, 24'h00004B);
    pinToggles(10, 3);
    tag = "R9"; setup(24'd3, 24'd6, 24'h00004F);
    pinToggles(10, 3);
    wr(2'd2, 24'h000100); idle(3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule